// File: doc/BRIEF.md
# Debug Transport Register Access over JTAG

This block is the test-access side of a debug transport. A standard 16-state TAP controller, clocked by `tck`, steps through capture, shift and update phases under `tms`. A 5-bit instruction register picks which data register sits between `tdi` and `tdo`: an identification word, a transport control word, a wide bus-access word, or a 1-bit bypass stage for any code it does not decode.

The bus-access word packs a request code, 32 data bits and a 6-bit target address into one 40-bit register. When that register is updated, a small sequencer turns the request into zero, one or two transfers on a debug module interface. That interface uses a valid/response handshake with an ok flag. The sequencer then stores a result code in the same 2-bit field that carried the request. On the next capture the field therefore reads back as a status, not a command. A read that fails stops the write that would have followed it.

The control word reports the address width, a version number, an idle-cycle hint and a sticky bus-error status. Setting its bus-reset bit clears that status.

Top module: `dtap_top`

## Requirements
- R1: Five consecutive `tck` rising edges with `tms`=1 put the TAP into Test-Logic-Reset from any state. That state, or `trst_n` low, loads the identification code 0x01 into the instruction register, so the next data scan returns the identification word.
- R2: The instruction register is 5 bits wide, shifted least significant bit first. Capture-IR loads 0b00001. Code 0x01 selects identification, 0x10 selects control and 0x11 selects bus access.
- R3: The identification word holds a version in bits 31:28, a part number in bits 27:12, a maker code in bits 11:1, and a 1 in bit 0.
- R4: The control word is 32 bits. Bits 3:0 hold version 1, bits 9:4 hold the address width (6), bits 11:10 hold the bus status, bits 14:12 hold the idle hint (default 0) and bit 16 is the bus-reset bit, which always reads 0. Its value after reset is 0x61.
- R5: The bus-access word is 40 bits: request/status code in bits 1:0, data in bits 33:2, address in bits 39:34. After reset it captures address 0, data 0 and status 2 (failed). The stored status is only ever 0 (success) or 2 (failed).
- R6: Request code 1 issues one read. A successful read puts the returned data in the data field and status 0. A failed read leaves the shifted-in data in the data field and sets status 2.
- R7: Request code 2 issues a read, then a write of the shifted-in data to the same address, but only if the read succeeded. The status is 0 only if both transfers succeed, otherwise 2. A successful read replaces the data field even when the write then fails.
- R8: Request codes 0 and 3 issue no transfer. They store the shifted address and data and set status 0.
- R9: Bus status in the control word becomes 2 after any failed bus-access request and stays there. Updating the control register with bit 16 set clears it to 0. All other written bits are ignored.
- R10: Any instruction code other than the three decoded ones selects a 1-bit bypass register that captures 0.
- R11: Once raised, `dm_req_valid` stays high, with address and direction unchanged, until a cycle in which `dm_resp_valid` is high. At most one transfer is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| trst_n | input | 1 | Asynchronous active-low reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (LSB of the selected shift register) |
| dm_req_valid | output | 1 | Transfer request to the debug module |
| dm_req_write | output | 1 | 1 = write, 0 = read |
| dm_req_addr | output | 6 | Target register address |
| dm_req_wdata | output | 32 | Write data |
| dm_resp_valid | input | 1 | Response for the outstanding request |
| dm_resp_ok | input | 1 | 1 = transfer succeeded |
| dm_resp_rdata | input | 32 | Read data, valid with a successful read response |

## Verification
The bench sweeps every one of the 64 addresses with all four request codes against a bench-side target. That target has three address ranges: readable and writable, read-only, and unmapped. The combinations therefore cover read success, read failure, write failure after a good read, and the write suppressed after a failed read. Counters of observed reads and writes tell a suppressed write apart from a failed one. Data written in earlier sweep steps shows up again in later reads. Separate scans cover the reset words, instruction capture, bypass delay, the sticky status with and without bit 16, and a TAP reset taken from the middle of a data shift.

// File: rtl/dtap_pkg.sv
package dtap_pkg;

   typedef enum logic [3:0] {
      TS_TLR    = 4'd0,
      TS_RTI    = 4'd1,
      TS_SELDR  = 4'd2,
      TS_CAPDR  = 4'd3,
      TS_SHDR   = 4'd4,
      TS_EX1DR  = 4'd5,
      TS_PAUDR  = 4'd6,
      TS_EX2DR  = 4'd7,
      TS_UPDDR  = 4'd8,
      TS_SELIR  = 4'd9,
      TS_CAPIR  = 4'd10,
      TS_SHIR   = 4'd11,
      TS_EX1IR  = 4'd12,
      TS_PAUIR  = 4'd13,
      TS_EX2IR  = 4'd14,
      TS_UPDIR  = 4'd15
   } tap_state_e;

   typedef enum logic [1:0] {
      DS_ID   = 2'd0,
      DS_CTRL = 2'd1,
      DS_BUS  = 2'd2,
      DS_BYP  = 2'd3
   } dr_sel_e;

   localparam logic [1:0] REQ_NOP  = 2'd0;
   localparam logic [1:0] REQ_RD   = 2'd1;
   localparam logic [1:0] REQ_RW   = 2'd2;
   localparam logic [1:0] STAT_OK   = 2'd0;
   localparam logic [1:0] STAT_FAIL = 2'd2;

endpackage

// File: rtl/dtap_fsm.sv
module dtap_fsm
   import dtap_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_e state
);

   tap_state_e nxt;

   always_comb begin
      nxt = state;
      case (state)
         TS_TLR:   nxt = tms ? TS_TLR   : TS_RTI;
         TS_RTI:   nxt = tms ? TS_SELDR : TS_RTI;
         TS_SELDR: nxt = tms ? TS_SELIR : TS_CAPDR;
         TS_CAPDR: nxt = tms ? TS_EX1DR : TS_SHDR;
         TS_SHDR:  nxt = tms ? TS_EX1DR : TS_SHDR;
         TS_EX1DR: nxt = tms ? TS_UPDDR : TS_PAUDR;
         TS_PAUDR: nxt = tms ? TS_EX2DR : TS_PAUDR;
         TS_EX2DR: nxt = tms ? TS_UPDDR : TS_SHDR;
         TS_UPDDR: nxt = tms ? TS_SELDR : TS_RTI;
         TS_SELIR: nxt = tms ? TS_TLR   : TS_CAPIR;
         TS_CAPIR: nxt = tms ? TS_EX1IR : TS_SHIR;
         TS_SHIR:  nxt = tms ? TS_EX1IR : TS_SHIR;
         TS_EX1IR: nxt = tms ? TS_UPDIR : TS_PAUIR;
         TS_PAUIR: nxt = tms ? TS_EX2IR : TS_PAUIR;
         TS_EX2IR: nxt = tms ? TS_UPDIR : TS_SHIR;
         TS_UPDIR: nxt = tms ? TS_SELDR : TS_RTI;
         default:  nxt = TS_TLR;
      endcase
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= TS_TLR;
      else         state <= nxt;
   end

endmodule

// File: rtl/dtap_ir.sv
module dtap_ir
   import dtap_pkg::*;
#(
   parameter int          IR_W       = 5,
   parameter logic [IR_W-1:0] RESET_CODE = 5'h01
) (
   input  logic            tck,
   input  logic            trst_n,
   input  tap_state_e      state,
   input  logic            tdi,
   output logic [IR_W-1:0] ir_q,
   output logic            ir_tdo
);

   localparam logic [IR_W-1:0] CAPTURE_PAT = IR_W'(1);

   logic [IR_W-1:0] ir_sr;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_sr <= '0;
         ir_q  <= RESET_CODE;
      end else begin
         case (state)
            TS_TLR:   ir_q  <= RESET_CODE;
            TS_CAPIR: ir_sr <= CAPTURE_PAT;
            TS_SHIR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
            TS_UPDIR: ir_q  <= ir_sr;
            default:  ;
         endcase
      end
   end

   assign ir_tdo = ir_sr[0];

endmodule

// File: rtl/dtap_bus_engine.sv
module dtap_bus_engine
   import dtap_pkg::*;
#(
   parameter int ABITS = 6,
   parameter int DW    = 32
) (
   input  logic             tck,
   input  logic             trst_n,
   input  logic             go,
   input  logic [1:0]       go_op,
   input  logic [ABITS-1:0] go_addr,
   input  logic [DW-1:0]    go_wdata,
   output logic             busy,
   output logic             done,
   output logic [1:0]       status,
   output logic             rd_good,
   output logic [DW-1:0]    rd_data,
   output logic             req_valid,
   output logic             req_write,
   output logic [ABITS-1:0] req_addr,
   output logic [DW-1:0]    req_wdata,
   input  logic             resp_valid,
   input  logic             resp_ok,
   input  logic [DW-1:0]    resp_rdata
);

   typedef enum logic [1:0] { EN_IDLE, EN_RD, EN_WR } eng_state_e;

   eng_state_e       st;
   logic [1:0]       op_q;
   logic [ABITS-1:0] addr_q;
   logic [DW-1:0]    wdata_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         st      <= EN_IDLE;
         op_q    <= REQ_NOP;
         addr_q  <= '0;
         wdata_q <= '0;
         done    <= 1'b0;
         status  <= STAT_FAIL;
         rd_good <= 1'b0;
         rd_data <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            EN_IDLE: begin
               if (go) begin
                  op_q    <= go_op;
                  addr_q  <= go_addr;
                  wdata_q <= go_wdata;
                  rd_good <= 1'b0;
                  if (go_op == REQ_RD || go_op == REQ_RW) begin
                     st <= EN_RD;
                  end else begin
                     done   <= 1'b1;
                     status <= STAT_OK;
                  end
               end
            end
            EN_RD: begin
               if (resp_valid) begin
                  if (resp_ok) begin
                     rd_data <= resp_rdata;
                     rd_good <= 1'b1;
                     if (op_q == REQ_RW) begin
                        st <= EN_WR;
                     end else begin
                        st     <= EN_IDLE;
                        done   <= 1'b1;
                        status <= STAT_OK;
                     end
                  end else begin
                     st     <= EN_IDLE;
                     done   <= 1'b1;
                     status <= STAT_FAIL;
                  end
               end
            end
            EN_WR: begin
               if (resp_valid) begin
                  st     <= EN_IDLE;
                  done   <= 1'b1;
                  status <= resp_ok ? STAT_OK : STAT_FAIL;
               end
            end
            default: st <= EN_IDLE;
         endcase
      end
   end

   assign busy      = (st != EN_IDLE);
   assign req_valid = (st == EN_RD) || (st == EN_WR);
   assign req_write = (st == EN_WR);
   assign req_addr  = addr_q;
   assign req_wdata = wdata_q;

endmodule

// File: rtl/dtap_top.sv
module dtap_top
   import dtap_pkg::*;
#(
   parameter int          ABITS       = 6,
   parameter int          IR_W        = 5,
   parameter logic [IR_W-1:0] IR_IDCODE = 5'h01,
   parameter logic [IR_W-1:0] IR_CTRL   = 5'h10,
   parameter logic [IR_W-1:0] IR_BUS    = 5'h11,
   parameter logic [3:0]  ID_VERSION  = 4'h1,
   parameter logic [15:0] ID_PART     = 16'hD7A3,
   parameter logic [10:0] ID_MAKER    = 11'h2B5,
   parameter logic [3:0]  XPORT_VER   = 4'd1,
   parameter logic [2:0]  IDLE_HINT   = 3'd0
) (
   input  logic             tck,
   input  logic             trst_n,
   input  logic             tms,
   input  logic             tdi,
   output logic             tdo,
   output logic             dm_req_valid,
   output logic             dm_req_write,
   output logic [ABITS-1:0] dm_req_addr,
   output logic [31:0]      dm_req_wdata,
   input  logic             dm_resp_valid,
   input  logic             dm_resp_ok,
   input  logic [31:0]      dm_resp_rdata
);

   localparam int DW      = 32;
   localparam int BUS_W   = ABITS + DW + 2;
   localparam int DR_W    = (BUS_W > 32) ? BUS_W : 32;
   localparam int LW      = $clog2(DR_W);
   localparam int CTRL_RST_BIT = 16;

   if (ABITS < 1 || ABITS > 63) begin : g_bad_abits
      $error("dtap_top: ABITS must be 1..63");
   end
   if (IR_W < 5) begin : g_bad_irw
      $error("dtap_top: IR_W must hold the 5-bit instruction codes");
   end

   tap_state_e       tap_state;
   logic [IR_W-1:0]  ir_q;
   logic             ir_tdo;

   dtap_fsm u_fsm (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .state  (tap_state)
   );

   dtap_ir #(.IR_W(IR_W), .RESET_CODE(IR_IDCODE)) u_ir (
      .tck    (tck),
      .trst_n (trst_n),
      .state  (tap_state),
      .tdi    (tdi),
      .ir_q   (ir_q),
      .ir_tdo (ir_tdo)
   );

   // data register selection
   dr_sel_e dr_sel;
   always_comb begin
      if      (ir_q == IR_IDCODE) dr_sel = DS_ID;
      else if (ir_q == IR_CTRL)   dr_sel = DS_CTRL;
      else if (ir_q == IR_BUS)    dr_sel = DS_BUS;
      else                        dr_sel = DS_BYP;
   end

   // stored register state
   logic [1:0]       ctrl_stat;
   logic [ABITS-1:0] bus_addr;
   logic [DW-1:0]    bus_data;
   logic [1:0]       bus_op;

   logic [31:0]      id_word;
   logic [31:0]      ctrl_word;
   logic [BUS_W-1:0] bus_word;

   assign id_word   = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};
   assign ctrl_word = {15'd0, 1'b0, 1'b0, IDLE_HINT, ctrl_stat, 6'(ABITS), XPORT_VER};
   assign bus_word  = {bus_addr, bus_data, bus_op};

   logic [DR_W-1:0] dr_sr;
   logic [DR_W-1:0] dr_cap;
   logic [DR_W-1:0] dr_nxt;
   logic [LW-1:0]   dr_msb;

   always_comb begin
      case (dr_sel)
         DS_ID:   begin dr_cap = DR_W'(id_word);   dr_msb = LW'(31);        end
         DS_CTRL: begin dr_cap = DR_W'(ctrl_word); dr_msb = LW'(31);        end
         DS_BUS:  begin dr_cap = DR_W'(bus_word);  dr_msb = LW'(BUS_W - 1); end
         default: begin dr_cap = '0;               dr_msb = '0;             end
      endcase
   end

   always_comb begin
      dr_nxt         = dr_sr >> 1;
      dr_nxt[dr_msb] = tdi;
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         dr_sr <= '0;
      end else if (tap_state == TS_CAPDR) begin
         dr_sr <= dr_cap;
      end else if (tap_state == TS_SHDR) begin
         dr_sr <= dr_nxt;
      end
   end

   // bus access sequencer
   logic             eng_busy;
   logic             eng_done;
   logic [1:0]       eng_status;
   logic             eng_rd_good;
   logic [DW-1:0]    eng_rd_data;
   logic             eng_go;

   assign eng_go = (tap_state == TS_UPDDR) && (dr_sel == DS_BUS) && !eng_busy;

   dtap_bus_engine #(.ABITS(ABITS), .DW(DW)) u_eng (
      .tck        (tck),
      .trst_n     (trst_n),
      .go         (eng_go),
      .go_op      (dr_sr[1:0]),
      .go_addr    (dr_sr[BUS_W-1:DW+2]),
      .go_wdata   (dr_sr[DW+1:2]),
      .busy       (eng_busy),
      .done       (eng_done),
      .status     (eng_status),
      .rd_good    (eng_rd_good),
      .rd_data    (eng_rd_data),
      .req_valid  (dm_req_valid),
      .req_write  (dm_req_write),
      .req_addr   (dm_req_addr),
      .req_wdata  (dm_req_wdata),
      .resp_valid (dm_resp_valid),
      .resp_ok    (dm_resp_ok),
      .resp_rdata (dm_resp_rdata)
   );

   // register updates
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ctrl_stat <= STAT_OK;
         bus_addr  <= '0;
         bus_data  <= '0;
         bus_op    <= STAT_FAIL;
      end else begin
         if (tap_state == TS_UPDDR && dr_sel == DS_CTRL && dr_sr[CTRL_RST_BIT]) begin
            ctrl_stat <= STAT_OK;
         end
         if (eng_go) begin
            bus_addr <= dr_sr[BUS_W-1:DW+2];
            bus_data <= dr_sr[DW+1:2];
         end
         if (eng_done) begin
            bus_op <= eng_status;
            if (eng_rd_good) bus_data <= eng_rd_data;
            if (eng_status == STAT_FAIL) ctrl_stat <= STAT_FAIL;
         end
      end
   end

   assign tdo = (tap_state == TS_SHIR) ? ir_tdo : dr_sr[0];

endmodule

// File: rtl/dtap_chk.sv
module dtap_chk #(
   parameter int          ABITS    = 6,
   parameter int          IR_W     = 5,
   parameter logic [IR_W-1:0] IR_RESET = 5'h01
) (
   input logic             tck,
   input logic             trst_n,
   input logic [3:0]       tap_state,
   input logic [IR_W-1:0]  ir_q,
   input logic             dm_req_valid,
   input logic             dm_req_write,
   input logic [ABITS-1:0] dm_req_addr,
   input logic             dm_resp_valid,
   input logic             dm_resp_ok,
   input logic [1:0]       bus_op,
   input logic [1:0]       ctrl_stat
);

   AST_IR_RESET: assert property (@(posedge tck) disable iff (!trst_n)
      (tap_state == 4'd0) |=> (ir_q == IR_RESET));  // R1

   AST_BUS_STATUS_CODE: assert property (@(posedge tck) disable iff (!trst_n)
      (bus_op == 2'd0) || (bus_op == 2'd2));  // R5

   AST_WRITE_NEEDS_READ: assert property (@(posedge tck) disable iff (!trst_n)
      $rose(dm_req_write) |-> $past(dm_resp_valid && dm_resp_ok));  // R7

   AST_CTRL_STATUS_CODE: assert property (@(posedge tck) disable iff (!trst_n)
      (ctrl_stat == 2'd0) || (ctrl_stat == 2'd2));  // R9

   AST_REQ_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
      (dm_req_valid && !dm_resp_valid) |=>
         (dm_req_valid && $stable(dm_req_addr) && $stable(dm_req_write)));  // R11

endmodule

bind dtap_top dtap_chk #(.ABITS(ABITS), .IR_W(IR_W), .IR_RESET(IR_IDCODE)) u_chk (
   .tck           (tck),
   .trst_n        (trst_n),
   .tap_state     (tap_state),
   .ir_q          (ir_q),
   .dm_req_valid  (dm_req_valid),
   .dm_req_write  (dm_req_write),
   .dm_req_addr   (dm_req_addr),
   .dm_resp_valid (dm_resp_valid),
   .dm_resp_ok    (dm_resp_ok),
   .bus_op        (bus_op),
   .ctrl_stat     (ctrl_stat)
);

// File: tb/sim_dtap_top.sv
`timescale 1ns/1ps
module sim_dtap_top;

   logic        tck = 1'b0;
   logic        trst_n = 1'b0;
   logic        tms = 1'b1;
   logic        tdi = 1'b0;
   logic        tdo;
   logic        req_valid, req_write;
   logic [5:0]  req_addr;
   logic [31:0] req_wdata;
   logic        resp_valid = 1'b0;
   logic        resp_ok = 1'b0;
   logic [31:0] resp_rdata = '0;

   int checks = 0;
   int fails  = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;
   int viol   = 0;
   bit finished = 0;
   logic tdo_s;

   logic [31:0] mem     [0:31];
   logic [31:0] exp_mem [0:31];

   always #4 tck = ~tck;

   dtap_top u0 (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
      .dm_req_valid(req_valid), .dm_req_write(req_write),
      .dm_req_addr(req_addr), .dm_req_wdata(req_wdata),
      .dm_resp_valid(resp_valid), .dm_resp_ok(resp_ok),
      .dm_resp_rdata(resp_rdata)
   );

   function automatic logic [31:0] seed_val(input int a);
      return 32'h5A00_0000 ^ (32'(a) * 32'h0103_0507);
   endfunction

   // debug module model: 0..31 read/write, 32..47 read-only, 48..63 unmapped
   always @(posedge tck) begin
      if (resp_valid) begin
         resp_valid <= 1'b0;
         if (!req_valid) viol <= viol + 1;
      end else if (req_valid) begin
         resp_valid <= 1'b1;
         if (req_write) begin
            wr_cnt <= wr_cnt + 1;
            if (req_addr < 6'd32) begin
               resp_ok <= 1'b1;
               mem[req_addr[4:0]] <= req_wdata;
            end else begin
               resp_ok <= 1'b0;
            end
         end else begin
            rd_cnt <= rd_cnt + 1;
            if (req_addr < 6'd32) begin
               resp_ok <= 1'b1; resp_rdata <= mem[req_addr[4:0]];
            end else if (req_addr < 6'd48) begin
               resp_ok <= 1'b1; resp_rdata <= seed_val(int'(req_addr));
            end else begin
               resp_ok <= 1'b0; resp_rdata <= 32'hDEAD_BEEF;
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic m, input logic d);
      @(negedge tck);
      tms = m;
      tdi = d;
      #1;
      tdo_s = tdo;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0);
   endtask

   task automatic scan_ir(input logic [4:0] code, output logic [4:0] cap);
      cap = '0;
      step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
      for (int i = 0; i < 5; i++) begin
         step(i == 4, code[i]);
         cap[i] = tdo_s;
      end
      step(1'b1, 1'b0); step(1'b0, 1'b0);
   endtask

   task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
      dout = '0;
      step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
      for (int i = 0; i < n; i++) begin
         step(i == n - 1, din[i]);
         dout[i] = tdo_s;
      end
      step(1'b1, 1'b0); step(1'b0, 1'b0);
   endtask

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge tck);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog R1 act=running exp=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [4:0]  ircap;
      logic [63:0] dout;
      logic [31:0] exp_id, exp_ctrl;
      for (int i = 0; i < 32; i++) begin
         mem[i]     = seed_val(i);
         exp_mem[i] = seed_val(i);
      end
      exp_id   = (32'h1 << 28) | (32'hD7A3 << 12) | (32'h2B5 << 1) | 32'h1;
      exp_ctrl = (32'd6 << 4) | 32'd1;

      repeat (3) @(negedge tck);
      trst_n = 1'b1;
      step(1'b0, 1'b0);

      // R1 R3: reset selects identification
      scan_dr(32, 64'h0, dout);
      chk("R3 id word after reset (R1)", dout[31:0], exp_id);

      // R2: IR capture pattern
      scan_ir(5'h10, ircap);
      chk("R2 ir capture", 64'(ircap), 64'h1);

      // R4: control reset value
      scan_dr(32, 64'h0, dout);
      chk("R4 ctrl reset", dout[31:0], exp_ctrl);

      // R5: bus register reset value
      scan_ir(5'h11, ircap);
      chk("R2 ir capture again", 64'(ircap), 64'h1);
      scan_dr(40, 64'h0, dout);
      chk("R5 bus reset word", dout[39:0], 40'h2);
      idle(8);

      // main sweep: every address, every request code
      for (int a = 0; a < 64; a++) begin
         for (int op = 0; op < 4; op++) begin
            logic [31:0] d, exp_d;
            logic [1:0]  exp_st;
            int          erd, ewr;
            string       tag;
            d      = 32'h3C00_0000 + (32'(a) << 8) + 32'(op * 17) + 32'(a * op);
            exp_d  = d;
            exp_st = 2'd0;
            erd    = rd_cnt;
            ewr    = wr_cnt;
            tag    = (op == 1) ? "R6" : (op == 2) ? "R7" : "R8";
            if (op == 1 || op == 2) begin
               erd++;
               if (a < 48) begin
                  exp_d = (a < 32) ? exp_mem[a] : seed_val(a);
                  if (op == 2) begin
                     ewr++;
                     if (a < 32) exp_mem[a] = d;
                     else        exp_st = 2'd2;
                  end
               end else begin
                  exp_st = 2'd2;
               end
            end
            scan_dr(40, {24'h0, 6'(a), d, 2'(op)}, dout);
            idle(8);
            scan_dr(40, 64'h0, dout);
            chk($sformatf("%s bus word a=%0d op=%0d", tag, a, op), dout[39:0],
                {6'(a), exp_d, exp_st});
            chk($sformatf("%s read count a=%0d op=%0d", tag, a, op), 64'(rd_cnt), 64'(erd));
            chk($sformatf("R7 write count a=%0d op=%0d", a, op), 64'(wr_cnt), 64'(ewr));
         end
      end

      // R6: later reads see data written by the sweep
      for (int a = 0; a < 32; a += 7) begin
         scan_dr(40, {24'h0, 6'(a), 32'h0, 2'd1}, dout);
         idle(8);
         scan_dr(40, 64'h0, dout);
         chk($sformatf("R6 readback a=%0d", a), dout[39:0], {6'(a), exp_mem[a], 2'd0});
      end

      // R9: sticky status and clear
      scan_ir(5'h10, ircap);
      scan_dr(32, 64'h0000_EFFF, dout);
      chk("R9 ctrl sticky fail", dout[31:0], exp_ctrl | (32'd2 << 10));
      scan_dr(32, 64'hFFFF_FFFF, dout);
      chk("R9 ctrl no clear without bit16", dout[31:0], exp_ctrl | (32'd2 << 10));
      scan_dr(32, 64'h0, dout);
      chk("R9 ctrl cleared by bit16", dout[31:0], exp_ctrl);

      // R10: bypass for undecoded codes
      scan_ir(5'h05, ircap);
      scan_dr(8, 64'hA5, dout);
      chk("R10 bypass 0x05", dout[7:0], 64'h4A);
      scan_ir(5'h1F, ircap);
      scan_dr(8, 64'h3C, dout);
      chk("R10 bypass 0x1F", dout[7:0], 64'h78);

      // R1: TAP reset from mid-shift
      scan_ir(5'h10, ircap);
      step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      scan_dr(32, 64'h0, dout);
      chk("R1 tms reset restores id", dout[31:0], exp_id);

      // R11: handshake kept
      chk("R11 req dropped before response", 64'(viol), 64'h0);

      finished = 1;
      summary();
      $finish;
   end

endmodule